// File: doc/BRIEF.md
# Mode-Selectable Mixed-Sign Multiplier

The block multiplies two 16-bit operands, or one 16-bit operand and a 5-bit literal, under one of seven operand-sign and operand-width modes picked by a 3-bit code. Signed, unsigned and mixed-sign products all go through one 17x17 signed multiply core. To make this work, each operand is first widened to 17 bits. A signed operand has its top bit copied into the extra bit. An unsigned operand, or the literal, gets a zero in that bit.

A caller presents the operands, the literal, the mode and a one-cycle start strobe in the same cycle. On the next clock edge the low 32 bits of the core result are captured in the output register, and valid goes high for that one cycle. The product register holds its value until the next start.

Top module: `mixsign_mul`

## Requirements
- R1: While rst_ni is low, prod_o is 0 and valid_o is 0.
- R2: valid_o is high in exactly the cycle after a cycle with start_i high, and low otherwise.
- R3: Mode code 0 treats both operands as two's complement. prod_o is the low 32 bits of the signed product, for example 0x8000 x 0x8000 gives 0x40000000.
- R4: Mode code 1 treats both operands as unsigned, for example 0xFFFF x 0xFFFF gives 0xFFFE0001.
- R5: Mode code 2 treats op_a_i as unsigned and op_b_i as signed. Mode code 3 treats op_a_i as signed and op_b_i as unsigned. In both, prod_o is the low 32 bits of the product.
- R6: Mode codes 4 (op_a_i signed) and 5 (op_a_i unsigned) multiply op_a_i by lit_i, with lit_i taken as unsigned (0..31). op_b_i has no effect on the result in these modes.
- R7: Mode code 6 multiplies op_a_i[7:0] by op_b_i[7:0], both unsigned. Bits 15:8 of both operands have no effect, and prod_o[31:16] is 0.
- R8: Mode code 7 is reserved and yields prod_o = 0 whatever the operands.
- R9: In a cycle with start_i low, prod_o keeps its previous value regardless of the other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture a new product at the next edge |
| mode_i | input | 3 | Sign/width mode code (0..7) |
| op_a_i | input | 16 | First operand |
| op_b_i | input | 16 | Second operand |
| lit_i | input | 5 | Unsigned literal used in place of op_b_i in modes 4 and 5 |
| prod_o | output | 32 | Registered product, low 32 bits |
| valid_o | output | 1 | One-cycle strobe marking a new product |

## Verification
The assertions check the timing contract on every cycle: a start always brings a single valid pulse, valid never appears without a start, the product register holds still between starts, the 8-bit mode never sets the upper half, and the reserved code always yields zero. Only the bench scenarios can show that each sign mode picks the correct extension. They do this by comparing products against wide arithmetic at the corner values 0x8000, 0x7FFF and 0xFFFF, with a literal of 31, and with ignored operand bits changed.

// File: rtl/mixmul_pkg.sv
package mixmul_pkg;
  typedef enum logic [2:0] {
    MD_SS  = 3'd0,
    MD_UU  = 3'd1,
    MD_US  = 3'd2,
    MD_SU  = 3'd3,
    MD_SL  = 3'd4,
    MD_UL  = 3'd5,
    MD_BB  = 3'd6,
    MD_RSV = 3'd7
  } mode_e;

  typedef struct packed {
    logic a_sgn;
    logic b_sgn;
    logic b_lit;
    logic byte_en;
    logic kill;
  } ctrl_t;
endpackage

// File: rtl/mul_mode_dec.sv
module mul_mode_dec
  import mixmul_pkg::*;
(
  input  logic [2:0] mode_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    unique case (mode_e'(mode_i))
      MD_SS:   begin ctrl_o.a_sgn = 1'b1; ctrl_o.b_sgn = 1'b1; end
      MD_UU:   ;
      MD_US:   ctrl_o.b_sgn = 1'b1;
      MD_SU:   ctrl_o.a_sgn = 1'b1;
      MD_SL:   begin ctrl_o.a_sgn = 1'b1; ctrl_o.b_lit = 1'b1; end
      MD_UL:   ctrl_o.b_lit = 1'b1;
      MD_BB:   ctrl_o.byte_en = 1'b1;
      default: ctrl_o.kill = 1'b1;
    endcase
  end
endmodule

// File: rtl/mul_operand_ext.sv
module mul_operand_ext #(
  parameter int W  = 16,
  parameter int LW = 5,
  parameter int BW = 8,
  localparam int EW = W + 1
) (
  input  logic [W-1:0]         data_i,
  input  logic [LW-1:0]        lit_i,
  input  logic                 sgn_en_i,
  input  logic                 lit_en_i,
  input  logic                 byte_en_i,
  input  logic                 kill_i,
  output logic signed [EW-1:0] ext_o
);
  logic [W-1:0] base;
  logic         top_bit;

  always_comb begin
    if (lit_en_i)       base = {{(W-LW){1'b0}}, lit_i};
    else if (byte_en_i) base = {{(W-BW){1'b0}}, data_i[BW-1:0]};
    else                base = data_i;
  end

  // literal is never sign-extended
  assign top_bit = sgn_en_i & ~lit_en_i & base[W-1];
  assign ext_o   = kill_i ? '0 : {top_bit, base};
endmodule

// File: rtl/mul_core_s17.sv
module mul_core_s17 #(
  parameter int EW = 17,
  parameter int OW = 32
) (
  input  logic signed [EW-1:0] a_i,
  input  logic signed [EW-1:0] b_i,
  output logic        [OW-1:0] p_o
);
  logic signed [OW-1:0] a_w, b_w;

  // low OW bits of a signed product depend only on low OW bits of the operands
  assign a_w = OW'(a_i);
  assign b_w = OW'(b_i);
  assign p_o = a_w * b_w;
endmodule

// File: rtl/mixsign_mul.sv
module mixsign_mul
  import mixmul_pkg::*;
#(
  parameter int W  = 16,
  parameter int LW = 5,
  parameter int BW = 8,
  localparam int EW = W + 1,
  localparam int OW = 2 * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    mode_i,
  input  logic [W-1:0]  op_a_i,
  input  logic [W-1:0]  op_b_i,
  input  logic [LW-1:0] lit_i,
  output logic [OW-1:0] prod_o,
  output logic          valid_o
);
  ctrl_t                ctrl;
  logic signed [EW-1:0] a_ext, b_ext;
  logic        [OW-1:0] core_p;
  logic        [OW-1:0] prod_q;
  logic                 valid_q;

  mul_mode_dec u_dec (
    .mode_i (mode_i),
    .ctrl_o (ctrl)
  );

  mul_operand_ext #(.W(W), .LW(LW), .BW(BW)) u_ext_a (
    .data_i    (op_a_i),
    .lit_i     ('0),
    .sgn_en_i  (ctrl.a_sgn),
    .lit_en_i  (1'b0),
    .byte_en_i (ctrl.byte_en),
    .kill_i    (ctrl.kill),
    .ext_o     (a_ext)
  );

  mul_operand_ext #(.W(W), .LW(LW), .BW(BW)) u_ext_b (
    .data_i    (op_b_i),
    .lit_i     (lit_i),
    .sgn_en_i  (ctrl.b_sgn),
    .lit_en_i  (ctrl.b_lit),
    .byte_en_i (ctrl.byte_en),
    .kill_i    (ctrl.kill),
    .ext_o     (b_ext)
  );

  mul_core_s17 #(.EW(EW), .OW(OW)) u_core (
    .a_i (a_ext),
    .b_i (b_ext),
    .p_o (core_p)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= start_i;
      if (start_i) prod_q <= core_p;
    end
  end

  assign prod_o  = prod_q;
  assign valid_o = valid_q;

  AST_VALID_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);  // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);  // R2
  AST_PROD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(prod_o));  // R9
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_i == 3'd6) |=> prod_o[OW-1:W] == '0);  // R7
  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && mode_i == 3'd7) |=> prod_o == '0);  // R8
  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> (prod_o == '0 && !valid_o));  // R1
endmodule

// File: tb/mixsign_mul_tb_top.sv
`timescale 1ns/1ps
module mixsign_mul_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [15:0] a = '0, b = '0;
  logic [4:0]  lit = '0;
  logic [31:0] prod;
  logic        valid;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  mixsign_mul dut_i (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .mode_i (mode),
    .op_a_i (a), .op_b_i (b), .lit_i (lit), .prod_o (prod), .valid_o (valid)
  );

  // {req, mode, a, b, lit, expected}
  localparam int NV = 13;
  localparam logic [75:0] VEC [NV] = '{
    {4'd3, 3'd0, 16'h8000, 16'h8000, 5'd0,  32'h40000000},  // R3
    {4'd3, 3'd0, 16'hFFFF, 16'h0003, 5'd0,  32'hFFFFFFFD},  // R3
    {4'd3, 3'd0, 16'h7FFF, 16'h8000, 5'd0,  32'hC0008000},  // R3
    {4'd4, 3'd1, 16'hFFFF, 16'hFFFF, 5'd0,  32'hFFFE0001},  // R4
    {4'd4, 3'd1, 16'h1234, 16'h0010, 5'd0,  32'h00012340},  // R4
    {4'd5, 3'd2, 16'hFFFF, 16'hFFFF, 5'd0,  32'hFFFF0001},  // R5
    {4'd5, 3'd2, 16'h0003, 16'h8000, 5'd0,  32'hFFFE8000},  // R5
    {4'd5, 3'd3, 16'hFFFF, 16'h0002, 5'd0,  32'hFFFFFFFE},  // R5
    {4'd5, 3'd3, 16'h8000, 16'hFFFF, 5'd0,  32'h80008000},  // R5
    {4'd6, 3'd4, 16'hFFFE, 16'hAAAA, 5'd31, 32'hFFFFFFC2},  // R6
    {4'd6, 3'd5, 16'hFFFF, 16'h5555, 5'd31, 32'h001EFFE1},  // R6
    {4'd7, 3'd6, 16'hABFF, 16'h12FF, 5'd7,  32'h0000FE01},  // R7
    {4'd8, 3'd7, 16'h1234, 16'h5678, 5'd9,  32'h00000000}   // R8
  };

  function automatic logic [31:0] ref_prod(logic [2:0] m, logic [15:0] x,
                                           logic [15:0] y, logic [4:0] l);
    longint sx, sy, ux, uy, r;
    sx = $signed(x); sy = $signed(y);
    ux = longint'({48'b0, x}); uy = longint'({48'b0, y});
    case (m)
      3'd0: r = sx * sy;
      3'd1: r = ux * uy;
      3'd2: r = ux * sy;
      3'd3: r = sx * uy;
      3'd4: r = sx * longint'({59'b0, l});
      3'd5: r = ux * longint'({59'b0, l});
      3'd6: r = longint'({56'b0, x[7:0]}) * longint'({56'b0, y[7:0]});
      default: r = 0;
    endcase
    return r[31:0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // issue one start, return the product sampled in the cycle valid is expected
  task automatic run(input logic [2:0] m, input logic [15:0] x, input logic [15:0] y,
                     input logic [4:0] l, output logic [31:0] p, output logic v);
    @(negedge clk);
    mode = m; a = x; b = y; lit = l; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    p = prod; v = valid;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] p, p2;
    logic        v;
    logic [31:0] seed;
    seed = 32'h1F2E3D4C;

    repeat (3) @(negedge clk);
    chk("R1 prod in reset", prod, 32'h0);
    chk("R1 valid in reset", {31'b0, valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", {31'b0, valid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][71:69], VEC[i][68:53], VEC[i][52:37], VEC[i][36:32], p, v);
      chk($sformatf("R%0d vec%0d", VEC[i][75:72], i), p, VEC[i][31:0]);
      chk("R2 valid with result", {31'b0, v}, 32'h1);
    end

    // R2: single-cycle pulse
    @(negedge clk);
    chk("R2 valid drops", {31'b0, valid}, 32'h0);

    // R9: inputs change with start low, product holds
    run(3'd1, 16'h0100, 16'h0100, 5'd0, p, v);
    chk("R4 0x100 squared", p, 32'h00010000);
    mode = 3'd0; a = 16'hFFFF; b = 16'h7FFF; lit = 5'd3;
    repeat (3) @(negedge clk);
    chk("R9 hold without start", prod, 32'h00010000);
    chk("R9 no valid without start", {31'b0, valid}, 32'h0);

    // R6: op_b has no effect in literal modes
    run(3'd4, 16'h8000, 16'h0000, 5'd31, p, v);
    run(3'd4, 16'h8000, 16'hFFFF, 5'd31, p2, v);
    chk("R6 op_b ignored", p2, p);
    chk("R6 0x8000 x 31 signed", p, 32'hFFF08000);

    // R7: upper operand bits ignored in byte mode
    run(3'd6, 16'hFF80, 16'h0003, 5'd0, p, v);
    chk("R7 upper bits ignored", p, 32'h00000180);

    // R2: back-to-back starts give valid every cycle
    @(negedge clk);
    mode = 3'd1; a = 16'd5; b = 16'd7; start = 1'b1;
    @(negedge clk);
    chk("R2 b2b first", prod, 32'd35);
    a = 16'd6;
    @(negedge clk);
    start = 1'b0;
    chk("R2 b2b second", prod, 32'd42);
    chk("R2 b2b valid", {31'b0, valid}, 32'h1);

    // sweep all codes with pseudo-random operands
    for (int k = 0; k < 400; k++) begin
      logic [2:0]  m;
      logic [15:0] x, y;
      logic [4:0]  l;
      seed = seed * 32'd1664525 + 32'd1013904223; x = seed[31:16];
      seed = seed * 32'd1664525 + 32'd1013904223; y = seed[31:16];
      seed = seed * 32'd1664525 + 32'd1013904223; l = seed[20:16];
      m = 3'(k % 8);
      run(m, x, y, l, p, v);
      chk($sformatf("R%0d sweep mode%0d", (m == 3'd0) ? 3 : (m == 3'd1) ? 4 :
                    (m < 3'd4) ? 5 : (m < 3'd6) ? 6 : (m == 3'd6) ? 7 : 8, m),
          p, ref_prod(m, x, y, l));
    end

    // R1: reset mid-operation clears outputs
    run(3'd1, 16'hFFFF, 16'hFFFF, 5'd0, p, v);
    rst_n = 1'b0;
    #1;
    chk("R1 async clear prod", prod, 32'h0);
    chk("R1 async clear valid", {31'b0, valid}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule